// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block runs a 10-bit successive-approximation conversion against an external comparator and resistor-ladder DAC. Software starts a conversion by writing 0 to the completion flag. The sequencer then clears its working register and tests one bit per trial, starting at the most significant bit. In each trial it sets the bit under test and shows the resulting code on the DAC output. On the last cycle of the trial's fixed interval it samples the comparator and keeps or drops that bit.

The sequence always lasts 122 clock cycles: one setup cycle, ten trials of 12 cycles each, and one store cycle. When the store cycle ends, the completion flag reads 1 again, the result stays frozen, and an interrupt request flag is raised. That flag stays set until software writes 0 to it. A code n stands for a trial voltage of n/1024 of the reference, and code 0 is zero volts.

Top module: `sar_adc_ctrl`

## Requirements
- R1: A write of 0 to the completion flag (`ctrl_we_i`=1, `ctrl_wdata_i`=0) starts a conversion, and `done_o` reads 0 from the next cycle. A write of 1 leaves `done_o`, `result_o` and `dac_code_o` unchanged.
- R2: On the clock edge that accepts a start, the result register is cleared to all zeros.
- R3: The first trial puts code 512 (only bit 9 set) on `dac_code_o`. `dac_code_o` always equals `result_o`. While a trial runs, every bit below the bit under test is 0.
- R4: Trials go from bit 9 down to bit 0. A bit under test stays 1 when `cmp_i` is 1 (input above the trial code) and is cleared otherwise. With a comparator that reads 1 when an integer input v is greater than the code, the final result is v-1 for v in 1..1024 and 0 for v = 0.
- R5: `done_o` returns to 1 exactly 122 clock edges after the edge that accepted the start.
- R6: At completion `irq_o` becomes 1. While idle, `result_o` holds its value.
- R7: `irq_o` stays 1 until a write of 0 to it (`irq_we_i`=1, `irq_wdata_i`=0). A write of 1 has no effect. A completion in the same cycle as a clear leaves the flag set.
- R8: A start accepted during a conversion restarts the sequence from the cleared state, and the 122-cycle count begins again.
- R9: `cmp_i` is sampled only on the last cycle of each trial, at edges 13+12k after the start edge (k = 0..9). Its value on any other cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Write strobe for the completion flag |
| ctrl_wdata_i | input | 1 | Value written to the completion flag (0 starts) |
| irq_we_i | input | 1 | Write strobe for the interrupt request flag |
| irq_wdata_i | input | 1 | Value written to the interrupt flag (0 clears) |
| cmp_i | input | 1 | Comparator: 1 when the analog input exceeds the trial voltage |
| done_o | output | 1 | Completion flag, 0 while converting |
| irq_o | output | 1 | Interrupt request flag |
| result_o | output | 10 | Result register |
| dac_code_o | output | 10 | Trial code driven to the DAC |

## Verification
On every cycle, the assertions check these properties: a start clears the register and drops the completion flag; bits below the bit under test stay zero; a low comparator sample clears its bit; completion raises both flags; and the interrupt flag holds without a clear. Other behaviour is shown only by the bench scenarios. These cover the exact 122-cycle length, the final code for every input level from 0 to 1024, restart in mid-conversion, and immunity to comparator glitches outside the sampling cycles.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_TRIAL,
    PH_STORE
  } phase_e;
endpackage

// File: rtl/sar_seq_timer.sv
module sar_seq_timer
  import sar_adc_pkg::*;
#(
  parameter int unsigned WIDTH        = 10,
  parameter int unsigned TRIAL_CYCLES = 12,
  localparam int unsigned IW = $clog2(WIDTH),
  localparam int unsigned CW = $clog2(TRIAL_CYCLES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output phase_e        phase_o,
  output logic [IW-1:0] bit_idx_o,
  output logic          setup_o,
  output logic          sample_o,
  output logic          store_o
);
  localparam logic [CW-1:0] LAST_CNT = CW'(TRIAL_CYCLES - 1);
  localparam logic [IW-1:0] TOP_IDX  = IW'(WIDTH - 1);

  phase_e        phase_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else if (start_i) begin
      phase_q <= PH_SETUP;
      cnt_q   <= '0;
      idx_q   <= TOP_IDX;
    end else begin
      unique case (phase_q)
        PH_SETUP: begin
          phase_q <= PH_TRIAL;
          cnt_q   <= '0;
          idx_q   <= TOP_IDX;
        end
        PH_TRIAL: begin
          if (cnt_q == LAST_CNT) begin
            cnt_q <= '0;
            if (idx_q == '0) phase_q <= PH_STORE;
            else             idx_q   <= idx_q - 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_STORE: phase_q <= PH_IDLE;
        default:  phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o   = phase_q;
  assign bit_idx_o = idx_q;
  assign setup_o   = (phase_q == PH_SETUP);
  assign sample_o  = (phase_q == PH_TRIAL) && (cnt_q == LAST_CNT);
  assign store_o   = (phase_q == PH_STORE);

  AST_STORE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_o && !start_i) |=> (phase_q == PH_IDLE)); // R5
endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg
  import sar_adc_pkg::*;
#(
  parameter int unsigned WIDTH = 10,
  localparam int unsigned IW = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             setup_i,
  input  logic             sample_i,
  input  phase_e           phase_i,
  input  logic [IW-1:0]    bit_idx_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] code_o
);
  logic [WIDTH-1:0] code_q, code_nxt;

  always_comb begin
    code_nxt = code_q;
    if (!cmp_i) code_nxt[bit_idx_i] = 1'b0;
    if (bit_idx_i != '0) code_nxt[bit_idx_i - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       code_q <= '0;
    else if (start_i)  code_q <= '0;
    else if (setup_i)  code_q <= {1'b1, {(WIDTH-1){1'b0}}};
    else if (sample_i) code_q <= code_nxt;
  end

  assign code_o = code_q;

  AST_LOWER_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_TRIAL) |-> ((code_q & ((WIDTH'(1) << bit_idx_i) - 1'b1)) == '0)); // R3
  AST_LOW_CMP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !start_i && !cmp_i) |=> (code_q[$past(bit_idx_i)] == 1'b0)); // R4
  AST_HIGH_CMP_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !start_i && cmp_i) |=> (code_q[$past(bit_idx_i)] == 1'b1)); // R4
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int unsigned WIDTH        = 10,
  parameter int unsigned TRIAL_CYCLES = 12,
  localparam int unsigned IW = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             ctrl_wdata_i,
  input  logic             irq_we_i,
  input  logic             irq_wdata_i,
  input  logic             cmp_i,
  output logic             done_o,
  output logic             irq_o,
  output logic [WIDTH-1:0] result_o,
  output logic [WIDTH-1:0] dac_code_o
);
  phase_e           phase;
  logic [IW-1:0]    bit_idx;
  logic             setup, sample, store;
  logic [WIDTH-1:0] code;
  logic             done_q, irq_q;

  // only a 0 written to the completion flag launches a conversion
  logic start;
  logic irq_clr;
  assign start   = ctrl_we_i && !ctrl_wdata_i;
  assign irq_clr = irq_we_i && !irq_wdata_i;

  sar_seq_timer #(.WIDTH(WIDTH), .TRIAL_CYCLES(TRIAL_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .phase_o   (phase),
    .bit_idx_o (bit_idx),
    .setup_o   (setup),
    .sample_o  (sample),
    .store_o   (store)
  );

  sar_bit_reg #(.WIDTH(WIDTH)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .setup_i   (setup),
    .sample_i  (sample),
    .phase_i   (phase),
    .bit_idx_i (bit_idx),
    .cmp_i     (cmp_i),
    .code_o    (code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     done_q <= 1'b1;
    else if (start)  done_q <= 1'b0;
    else if (store)  done_q <= 1'b1;
  end

  // completion outranks a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             irq_q <= 1'b0;
    else if (store && !start) irq_q <= 1'b1;
    else if (irq_clr)        irq_q <= 1'b0;
  end

  assign done_o     = done_q;
  assign irq_o      = irq_q;
  assign result_o   = code;
  assign dac_code_o = code;

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (result_o == '0)); // R2
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !done_o); // R1
  AST_STORE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store && !start) |=> (done_o && irq_o)); // R6
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr) |=> irq_o); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start) |=> $stable(result_o)); // R6
endmodule

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_we = 1'b0, ctrl_wdata = 1'b0, irq_we = 1'b0, irq_wdata = 1'b0;
  logic cmp;
  logic done, irq;
  logic [9:0] result, dac;
  int vin = 0;
  logic garble = 1'b0;
  logic sample_win = 1'b0;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  // comparator model: 1 when input level exceeds trial code; optional glitching off-sample
  always_comb begin
    cmp = (vin > int'(dac));
    if (garble && !sample_win) cmp = !cmp;
  end

  sar_adc_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .irq_we_i(irq_we), .irq_wdata_i(irq_wdata),
    .cmp_i(cmp),
    .done_o(done), .irq_o(irq), .result_o(result), .dac_code_o(dac)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_code(input int v);
    if (v <= 0) return 0;
    if (v > 1023) return 1023;
    return v - 1;
  endfunction

  // full conversion, clears irq together with the start
  task automatic run_conv(input int v, input bit glitch, input string req);
    @(negedge clk);
    vin = v; garble = glitch; sample_win = 1'b0;
    ctrl_we = 1'b1; ctrl_wdata = 1'b0; irq_we = 1'b1; irq_wdata = 1'b0;
    @(posedge clk);
    @(negedge clk);
    ctrl_we = 1'b0; irq_we = 1'b0;
    check(result == 10'd0, "R2 cleared at start", int'(result), 0);
    check(done == 1'b0, "R1 done low after start", int'(done), 0);
    for (int e = 1; e <= 122; e++) begin
      sample_win = (e >= 13) && (((e - 13) % 12) == 0);
      @(posedge clk);
      @(negedge clk);
      if (e == 1) check(dac == 10'd512, "R3 first trial code", int'(dac), 512);
      if (e == 121) check(done == 1'b0, "R5 done still low at 121", int'(done), 0);
      if (e == 121) check(irq == 1'b0, "R7 irq cleared before completion", int'(irq), 0);
    end
    sample_win = 1'b0;
    check(done == 1'b1, "R5 done at edge 122", int'(done), 1);
    check(irq == 1'b1, "R6 irq at completion", int'(irq), 1);
    check(int'(result) == expect_code(v), {req, " result"}, int'(result), expect_code(v));
    check(dac == result, "R3 dac equals result", int'(dac), int'(result));
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b1, "R1 reset done", int'(done), 1);
    check(irq == 1'b0, "R7 reset irq", int'(irq), 0);
    check(result == 10'd0, "R2 reset result", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: exhaustive sweep of input levels
    for (int v = 0; v <= 1024; v++) run_conv(v, 1'b0, "R4 sweep");

    // R6/R7: irq and result held while idle; write 1 ignored
    repeat (20) @(negedge clk);
    check(irq == 1'b1, "R7 irq held", int'(irq), 1);
    check(int'(result) == 1023, "R6 result held idle", int'(result), 1023);
    irq_we = 1'b1; irq_wdata = 1'b1;
    @(negedge clk);
    irq_we = 1'b0;
    check(irq == 1'b1, "R7 irq write 1 no effect", int'(irq), 1);
    irq_we = 1'b1; irq_wdata = 1'b0;
    @(negedge clk);
    irq_we = 1'b0;
    check(irq == 1'b0, "R7 irq cleared", int'(irq), 0);
    irq_we = 1'b1; irq_wdata = 1'b1;
    @(negedge clk);
    irq_we = 1'b0;
    check(irq == 1'b0, "R7 irq write 1 does not set", int'(irq), 0);

    // R1: write 1 to completion flag while idle
    ctrl_we = 1'b1; ctrl_wdata = 1'b1;
    @(negedge clk);
    ctrl_we = 1'b0;
    repeat (5) @(negedge clk);
    check(done == 1'b1, "R1 write 1 keeps done", int'(done), 1);
    check(int'(result) == 1023, "R1 write 1 keeps result", int'(result), 1023);
    check(int'(dac) == 1023, "R1 write 1 keeps dac", int'(dac), 1023);

    // R8: restart mid-conversion
    @(negedge clk);
    vin = 900; ctrl_we = 1'b1; ctrl_wdata = 1'b0;
    @(negedge clk);
    ctrl_we = 1'b0;
    repeat (60) @(negedge clk);
    check(done == 1'b0, "R8 busy before restart", int'(done), 0);
    run_conv(37, 1'b0, "R8 restart");
    run_conv(700, 1'b0, "R8 after restart");

    // R9: comparator glitches outside sample cycles ignored
    run_conv(613, 1'b1, "R9 glitch");
    run_conv(1, 1'b1, "R9 glitch low");
    run_conv(1024, 1'b1, "R9 glitch high");
    run_conv(342, 1'b1, "R9 glitch mid");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule